// File: doc/BRIEF.md
# Adaptive Receiver Immunity Controller

This block keeps five receiver-tuning settings and moves them one rung at a time as receive-error events arrive. The settings are a noise immunity level, a spur immunity level, a first-step level, an OFDM weak-signal-detect switch and a CCK weak-signal threshold select. A controller raises immunity when OFDM or CCK error counts trip their limits. It lowers immunity when a quiet interval passes. It can also write a single setting directly, or return everything to its defaults when the channel changes.

Raising and lowering follow a fixed ladder. Noise immunity is raised first, then spur immunity. After that the beacon RSSI picks among three branches: above the high threshold, between the two thresholds, or at or below the low threshold. Those branches decide what happens to weak-signal detection and the first-step level. A channel-is-CCK flag allows the low-RSSI branches to act. An RSSI enable input can switch the RSSI branches off completely. Every event is answered with a one-cycle done pulse, and every level change is marked by an up or down strobe. The translation of these settings into PHY register values happens outside this block.

Top module: `rx_immunity_ctrl`

## Requirements
- R1: Events are sampled on a rising clock edge. If several arrive together, only the highest one acts, in the order reset request, set command, OFDM trigger, CCK trigger, lower request, and the others are dropped. One cycle after any event `done_o` is high for exactly one cycle. With no event, the settings hold and `done_o` stays low.
- R2: Power-on reset, and a reset request with `restore_i` low, give noise = spur = first-step = 0, weak-signal detect on (`wsd_on_o`=1) and the CCK threshold low (`cck_thr_hi_o`=0). A reset request with `restore_i` high leaves every setting unchanged.
- R3: An OFDM trigger raises noise immunity by one if it is below `max_ni_i`. Otherwise it raises spur immunity by one if that is below `max_si_i`. Only when both are at their maximum does it fall to the RSSI branches.
- R4: OFDM trigger, RSSI above the high threshold: if weak-signal detect is on, it is switched off and spur immunity is set to 0 in the same event. Otherwise the first-step level is raised by one if it is below `max_fs_i`.
- R5: OFDM trigger, RSSI above the low threshold but not above the high one: weak-signal detect is switched on if it is off, and in the same event the first-step level is raised by one if it is below its maximum.
- R6: OFDM trigger, RSSI at or below the low threshold: on a CCK channel weak-signal detect is switched off and the first-step level is set to 0. On a non-CCK channel nothing changes. With `rssi_en_i` low, the RSSI branches change nothing for any event.
- R7: A CCK trigger raises noise immunity by one if possible. Otherwise, with RSSI above the low threshold, it raises the first-step level if it is below its maximum. With low RSSI on a CCK channel, it sets the first-step level to 0. It never changes spur immunity or weak-signal detect.
- R8: A lower request with RSSI above the high threshold (or with `rssi_en_i` low) skips the RSSI step. It then lowers spur immunity by one if it is above 0, else lowers noise immunity by one if it is above 0.
- R9: A lower request with mid RSSI switches weak-signal detect on if it is off and stops. Otherwise it lowers the first-step level if that is above 0 and stops. Otherwise it continues with the spur/noise steps of R8.
- R10: A lower request with low RSSI lowers the first-step level by one if it is above 0 and stops. Otherwise it continues with the spur/noise steps of R8.
- R11: The set command writes `set_val_i` to the setting chosen by `set_sel_i`: 0 noise, 1 spur, 2 first-step, 3 weak-signal detect (bit 0), 4 CCK threshold (bit 0). Codes 5 to 7 change nothing. A level above its maximum input is rejected and leaves the state unchanged.
- R12: Each level has an up and a down strobe. A strobe is high in exactly the cycles where its level output is higher (up) or lower (down) than in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofdm_trig_i | input | 1 | OFDM error limit exceeded |
| cck_trig_i | input | 1 | CCK error limit exceeded |
| lower_req_i | input | 1 | Quiet interval elapsed, lower immunity |
| reset_req_i | input | 1 | Channel change: defaults or restore |
| restore_i | input | 1 | With reset_req_i: keep current settings |
| set_req_i | input | 1 | Direct write of one setting |
| set_sel_i | input | 3 | Setting selected by the set command |
| set_val_i | input | LVL_W | Value for the set command |
| rssi_i | input | RSSI_W | Beacon RSSI, signed |
| rssi_lo_i | input | RSSI_W | Low RSSI threshold, signed |
| rssi_hi_i | input | RSSI_W | High RSSI threshold, signed |
| rssi_en_i | input | 1 | Enables the RSSI branches |
| cck_chan_i | input | 1 | Current channel carries CCK |
| max_ni_i | input | LVL_W | Noise immunity maximum |
| max_si_i | input | LVL_W | Spur immunity maximum |
| max_fs_i | input | LVL_W | First-step maximum |
| ni_lvl_o | output | LVL_W | Noise immunity level |
| si_lvl_o | output | LVL_W | Spur immunity level |
| fs_lvl_o | output | LVL_W | First-step level |
| wsd_on_o | output | 1 | OFDM weak-signal detect enabled |
| cck_thr_hi_o | output | 1 | CCK weak-signal threshold high |
| ni_up_o | output | 1 | Noise level rose |
| ni_dn_o | output | 1 | Noise level fell |
| si_up_o | output | 1 | Spur level rose |
| si_dn_o | output | 1 | Spur level fell |
| fs_up_o | output | 1 | First-step level rose |
| fs_dn_o | output | 1 | First-step level fell |
| done_o | output | 1 | Event handled, one cycle |

## Verification
The assertions assume that the maximum inputs stay constant while events are in flight. They also assume the low RSSI threshold is not above the high one, so that the three RSSI ranges do not overlap. The stimulus sets the maxima once (2, 2, 2) and uses thresholds 10 and 40. It changes RSSI, the channel flag and the enable only between events, never in a cycle where an event is driven. The bench still drives simultaneous events on purpose, to exercise the priority order.

// File: rtl/imm_pkg.sv
package imm_pkg;

    // Winning event after priority arbitration
    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_RESET = 3'd1,
        EV_SET   = 3'd2,
        EV_OFDM  = 3'd3,
        EV_CCK   = 3'd4,
        EV_LOWER = 3'd5
    } imm_event_e;

    // RSSI range relative to the two thresholds
    typedef enum logic [1:0] {
        ZN_OFF  = 2'd0,
        ZN_LOW  = 2'd1,
        ZN_MID  = 2'd2,
        ZN_HIGH = 2'd3
    } rssi_zone_e;

    // Selector codes of the direct set command
    localparam logic [2:0] SEL_NI  = 3'd0;
    localparam logic [2:0] SEL_SI  = 3'd1;
    localparam logic [2:0] SEL_FS  = 3'd2;
    localparam logic [2:0] SEL_WSD = 3'd3;
    localparam logic [2:0] SEL_CCK = 3'd4;

endpackage

// File: rtl/imm_rssi_zone.sv
module imm_rssi_zone #(
    parameter int RSSI_W = 8
) (
    input  logic signed [RSSI_W-1:0] rssi_i,
    input  logic signed [RSSI_W-1:0] lo_i,
    input  logic signed [RSSI_W-1:0] hi_i,
    input  logic                     en_i,
    output imm_pkg::rssi_zone_e      zone_o
);
    import imm_pkg::*;

    always_comb begin
        if (!en_i)             zone_o = ZN_OFF;
        else if (rssi_i > hi_i) zone_o = ZN_HIGH;
        else if (rssi_i > lo_i) zone_o = ZN_MID;
        else                    zone_o = ZN_LOW;
    end

endmodule

// File: rtl/imm_event_arb.sv
module imm_event_arb (
    input  logic                ofdm_i,
    input  logic                cck_i,
    input  logic                lower_i,
    input  logic                reset_i,
    input  logic                set_i,
    output imm_pkg::imm_event_e ev_o
);
    import imm_pkg::*;

    // Fixed priority: reset, set, OFDM, CCK, lower
    always_comb begin
        if (reset_i)      ev_o = EV_RESET;
        else if (set_i)   ev_o = EV_SET;
        else if (ofdm_i)  ev_o = EV_OFDM;
        else if (cck_i)   ev_o = EV_CCK;
        else if (lower_i) ev_o = EV_LOWER;
        else              ev_o = EV_NONE;
    end

endmodule

// File: rtl/imm_ladder.sv
module imm_ladder #(
    parameter int LVL_W = 3
) (
    input  imm_pkg::imm_event_e ev_i,
    input  imm_pkg::rssi_zone_e zone_i,
    input  logic               cck_chan_i,
    input  logic               restore_i,
    input  logic [2:0]         set_sel_i,
    input  logic [LVL_W-1:0]   set_val_i,
    input  logic [LVL_W-1:0]   max_ni_i,
    input  logic [LVL_W-1:0]   max_si_i,
    input  logic [LVL_W-1:0]   max_fs_i,
    input  logic [LVL_W-1:0]   cur_ni_i,
    input  logic [LVL_W-1:0]   cur_si_i,
    input  logic [LVL_W-1:0]   cur_fs_i,
    input  logic               cur_wsd_i,
    input  logic               cur_cck_i,
    output logic [LVL_W-1:0]   nxt_ni_o,
    output logic [LVL_W-1:0]   nxt_si_o,
    output logic [LVL_W-1:0]   nxt_fs_o,
    output logic               nxt_wsd_o,
    output logic               nxt_cck_o
);
    import imm_pkg::*;

    localparam logic [LVL_W-1:0] LVL_ZERO = '0;
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    logic ni_can_up, si_can_up, fs_can_up;
    logic si_can_dn, ni_can_dn, fs_can_dn;
    logic rssi_took;

    assign ni_can_up = cur_ni_i < max_ni_i;
    assign si_can_up = cur_si_i < max_si_i;
    assign fs_can_up = cur_fs_i < max_fs_i;
    assign ni_can_dn = cur_ni_i != LVL_ZERO;
    assign si_can_dn = cur_si_i != LVL_ZERO;
    assign fs_can_dn = cur_fs_i != LVL_ZERO;

    always_comb begin
        nxt_ni_o  = cur_ni_i;
        nxt_si_o  = cur_si_i;
        nxt_fs_o  = cur_fs_i;
        nxt_wsd_o = cur_wsd_i;
        nxt_cck_o = cur_cck_i;
        rssi_took = 1'b0;
        unique case (ev_i)
            EV_RESET: begin
                if (!restore_i) begin
                    nxt_ni_o  = LVL_ZERO;
                    nxt_si_o  = LVL_ZERO;
                    nxt_fs_o  = LVL_ZERO;
                    nxt_wsd_o = 1'b1;
                    nxt_cck_o = 1'b0;
                end
            end
            EV_SET: begin
                unique case (set_sel_i)
                    SEL_NI:  if (set_val_i <= max_ni_i) nxt_ni_o = set_val_i;
                    SEL_SI:  if (set_val_i <= max_si_i) nxt_si_o = set_val_i;
                    SEL_FS:  if (set_val_i <= max_fs_i) nxt_fs_o = set_val_i;
                    SEL_WSD: nxt_wsd_o = set_val_i[0];
                    SEL_CCK: nxt_cck_o = set_val_i[0];
                    default: ;
                endcase
            end
            EV_OFDM: begin
                if (ni_can_up) begin
                    nxt_ni_o = cur_ni_i + LVL_ONE;
                end else if (si_can_up) begin
                    nxt_si_o = cur_si_i + LVL_ONE;
                end else begin
                    unique case (zone_i)
                        ZN_HIGH: begin
                            if (cur_wsd_i) begin
                                nxt_wsd_o = 1'b0;
                                nxt_si_o  = LVL_ZERO;
                            end else if (fs_can_up) begin
                                nxt_fs_o = cur_fs_i + LVL_ONE;
                            end
                        end
                        ZN_MID: begin
                            nxt_wsd_o = 1'b1;
                            if (fs_can_up) nxt_fs_o = cur_fs_i + LVL_ONE;
                        end
                        ZN_LOW: begin
                            if (cck_chan_i) begin
                                nxt_wsd_o = 1'b0;
                                nxt_fs_o  = LVL_ZERO;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            EV_CCK: begin
                if (ni_can_up) begin
                    nxt_ni_o = cur_ni_i + LVL_ONE;
                end else if (zone_i == ZN_HIGH || zone_i == ZN_MID) begin
                    if (fs_can_up) nxt_fs_o = cur_fs_i + LVL_ONE;
                end else if (zone_i == ZN_LOW && cck_chan_i) begin
                    nxt_fs_o = LVL_ZERO;
                end
            end
            EV_LOWER: begin
                unique case (zone_i)
                    ZN_MID: begin
                        if (!cur_wsd_i) begin
                            nxt_wsd_o = 1'b1;
                            rssi_took = 1'b1;
                        end else if (fs_can_dn) begin
                            nxt_fs_o  = cur_fs_i - LVL_ONE;
                            rssi_took = 1'b1;
                        end
                    end
                    ZN_LOW: begin
                        if (fs_can_dn) begin
                            nxt_fs_o  = cur_fs_i - LVL_ONE;
                            rssi_took = 1'b1;
                        end
                    end
                    default: ;
                endcase
                if (!rssi_took) begin
                    if (si_can_dn)      nxt_si_o = cur_si_i - LVL_ONE;
                    else if (ni_can_dn) nxt_ni_o = cur_ni_i - LVL_ONE;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_immunity_ctrl.sv
module rx_immunity_ctrl #(
    parameter int LVL_W  = 3,
    parameter int RSSI_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ofdm_trig_i,
    input  logic                     cck_trig_i,
    input  logic                     lower_req_i,
    input  logic                     reset_req_i,
    input  logic                     restore_i,
    input  logic                     set_req_i,
    input  logic [2:0]               set_sel_i,
    input  logic [LVL_W-1:0]         set_val_i,
    input  logic signed [RSSI_W-1:0] rssi_i,
    input  logic signed [RSSI_W-1:0] rssi_lo_i,
    input  logic signed [RSSI_W-1:0] rssi_hi_i,
    input  logic                     rssi_en_i,
    input  logic                     cck_chan_i,
    input  logic [LVL_W-1:0]         max_ni_i,
    input  logic [LVL_W-1:0]         max_si_i,
    input  logic [LVL_W-1:0]         max_fs_i,
    output logic [LVL_W-1:0]         ni_lvl_o,
    output logic [LVL_W-1:0]         si_lvl_o,
    output logic [LVL_W-1:0]         fs_lvl_o,
    output logic                     wsd_on_o,
    output logic                     cck_thr_hi_o,
    output logic                     ni_up_o,
    output logic                     ni_dn_o,
    output logic                     si_up_o,
    output logic                     si_dn_o,
    output logic                     fs_up_o,
    output logic                     fs_dn_o,
    output logic                     done_o
);
    import imm_pkg::*;

    typedef struct packed {
        logic [LVL_W-1:0] ni;
        logic [LVL_W-1:0] si;
        logic [LVL_W-1:0] fs;
        logic             wsd;
        logic             cck;
        logic             ni_up;
        logic             ni_dn;
        logic             si_up;
        logic             si_dn;
        logic             fs_up;
        logic             fs_dn;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ni: '0, si: '0, fs: '0, wsd: 1'b1, default: 1'b0};

    ctl_t ctl_d, ctl_q;

    imm_event_e ev;
    rssi_zone_e zone;
    logic [LVL_W-1:0] nxt_ni, nxt_si, nxt_fs;
    logic nxt_wsd, nxt_cck;

    imm_event_arb u_arb (
        .ofdm_i  (ofdm_trig_i),
        .cck_i   (cck_trig_i),
        .lower_i (lower_req_i),
        .reset_i (reset_req_i),
        .set_i   (set_req_i),
        .ev_o    (ev)
    );

    imm_rssi_zone #(.RSSI_W(RSSI_W)) u_zone (
        .rssi_i (rssi_i),
        .lo_i   (rssi_lo_i),
        .hi_i   (rssi_hi_i),
        .en_i   (rssi_en_i),
        .zone_o (zone)
    );

    imm_ladder #(.LVL_W(LVL_W)) u_ladder (
        .ev_i       (ev),
        .zone_i     (zone),
        .cck_chan_i (cck_chan_i),
        .restore_i  (restore_i),
        .set_sel_i  (set_sel_i),
        .set_val_i  (set_val_i),
        .max_ni_i   (max_ni_i),
        .max_si_i   (max_si_i),
        .max_fs_i   (max_fs_i),
        .cur_ni_i   (ctl_q.ni),
        .cur_si_i   (ctl_q.si),
        .cur_fs_i   (ctl_q.fs),
        .cur_wsd_i  (ctl_q.wsd),
        .cur_cck_i  (ctl_q.cck),
        .nxt_ni_o   (nxt_ni),
        .nxt_si_o   (nxt_si),
        .nxt_fs_o   (nxt_fs),
        .nxt_wsd_o  (nxt_wsd),
        .nxt_cck_o  (nxt_cck)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ni    = nxt_ni;
        ctl_d.si    = nxt_si;
        ctl_d.fs    = nxt_fs;
        ctl_d.wsd   = nxt_wsd;
        ctl_d.cck   = nxt_cck;
        ctl_d.ni_up = nxt_ni > ctl_q.ni;
        ctl_d.ni_dn = nxt_ni < ctl_q.ni;
        ctl_d.si_up = nxt_si > ctl_q.si;
        ctl_d.si_dn = nxt_si < ctl_q.si;
        ctl_d.fs_up = nxt_fs > ctl_q.fs;
        ctl_d.fs_dn = nxt_fs < ctl_q.fs;
        ctl_d.done  = ev != EV_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign ni_lvl_o     = ctl_q.ni;
    assign si_lvl_o     = ctl_q.si;
    assign fs_lvl_o     = ctl_q.fs;
    assign wsd_on_o     = ctl_q.wsd;
    assign cck_thr_hi_o = ctl_q.cck;
    assign ni_up_o      = ctl_q.ni_up;
    assign ni_dn_o      = ctl_q.ni_dn;
    assign si_up_o      = ctl_q.si_up;
    assign si_dn_o      = ctl_q.si_dn;
    assign fs_up_o      = ctl_q.fs_up;
    assign fs_dn_o      = ctl_q.fs_dn;
    assign done_o       = ctl_q.done;

endmodule

// File: rtl/imm_checker.sv
module imm_checker #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ofdm_trig_i,
    input logic             cck_trig_i,
    input logic             lower_req_i,
    input logic             reset_req_i,
    input logic             restore_i,
    input logic             set_req_i,
    input logic [2:0]       set_sel_i,
    input logic [LVL_W-1:0] set_val_i,
    input logic [LVL_W-1:0] max_ni_i,
    input logic [LVL_W-1:0] ni_lvl_o,
    input logic [LVL_W-1:0] si_lvl_o,
    input logic [LVL_W-1:0] fs_lvl_o,
    input logic             wsd_on_o,
    input logic             cck_thr_hi_o,
    input logic             ni_up_o,
    input logic             si_up_o,
    input logic             fs_dn_o,
    input logic             done_o
);
    logic any_ev;
    assign any_ev = ofdm_trig_i | cck_trig_i | lower_req_i | reset_req_i | set_req_i;

    // R1: every event is answered one cycle later
    p_done_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_ev |=> done_o);

    // R1: no event, no done and no change
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> !done_o && $stable({ni_lvl_o, si_lvl_o, fs_lvl_o, wsd_on_o, cck_thr_hi_o}));

    // R2: reset request without restore gives defaults
    p_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_i && !restore_i |=> ni_lvl_o == '0 && si_lvl_o == '0 && fs_lvl_o == '0
                                      && wsd_on_o && !cck_thr_hi_o);

    // R2: reset request with restore keeps everything
    p_restore_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_i && restore_i |=> $stable({ni_lvl_o, si_lvl_o, fs_lvl_o, wsd_on_o, cck_thr_hi_o}));

    // R3: an OFDM trigger moves noise immunity by at most one step up
    p_ofdm_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ofdm_trig_i && !reset_req_i && !set_req_i |=>
            (ni_lvl_o == $past(ni_lvl_o) || ni_lvl_o == $past(ni_lvl_o) + 1'b1));

    // R7: a CCK trigger leaves spur immunity and weak-signal detect alone
    p_cck_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cck_trig_i && !ofdm_trig_i && !reset_req_i && !set_req_i |=>
            $stable(si_lvl_o) && $stable(wsd_on_o));

    // R11: an out-of-range noise level write is rejected
    p_set_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_req_i && !reset_req_i && set_sel_i == 3'd0 && set_val_i > max_ni_i |=> $stable(ni_lvl_o));

    // R12: strobes agree with level movement
    p_ni_up_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ni_up_o |-> ni_lvl_o > $past(ni_lvl_o));
    p_si_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        si_lvl_o > $past(si_lvl_o) |-> si_up_o);
    p_fs_dn_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fs_dn_o |-> fs_lvl_o < $past(fs_lvl_o));

endmodule

bind rx_immunity_ctrl imm_checker #(.LVL_W(LVL_W)) u_imm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ofdm_trig_i  (ofdm_trig_i),
    .cck_trig_i   (cck_trig_i),
    .lower_req_i  (lower_req_i),
    .reset_req_i  (reset_req_i),
    .restore_i    (restore_i),
    .set_req_i    (set_req_i),
    .set_sel_i    (set_sel_i),
    .set_val_i    (set_val_i),
    .max_ni_i     (max_ni_i),
    .ni_lvl_o     (ni_lvl_o),
    .si_lvl_o     (si_lvl_o),
    .fs_lvl_o     (fs_lvl_o),
    .wsd_on_o     (wsd_on_o),
    .cck_thr_hi_o (cck_thr_hi_o),
    .ni_up_o      (ni_up_o),
    .si_up_o      (si_up_o),
    .fs_dn_o      (fs_dn_o),
    .done_o       (done_o)
);

// File: tb/test_rx_immunity_ctrl.sv
module test_rx_immunity_ctrl;
    localparam int LVL_W  = 3;
    localparam int RSSI_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ofdm = 0, cck = 0, lower = 0, rreq = 0, restore = 0, setr = 0;
    logic [2:0] sel = '0;
    logic [LVL_W-1:0] val = '0;
    logic signed [RSSI_W-1:0] rssi = 8'sd50;
    logic signed [RSSI_W-1:0] thr_lo = 8'sd10;
    logic signed [RSSI_W-1:0] thr_hi = 8'sd40;
    logic rssi_en = 1'b1, cck_chan = 1'b0;
    logic [LVL_W-1:0] max_ni = 3'd2, max_si = 3'd2, max_fs = 3'd2;
    logic [LVL_W-1:0] ni, si, fs;
    logic wsd, cckhi, ni_up, ni_dn, si_up, si_dn, fs_up, fs_dn, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_immunity_ctrl #(.LVL_W(LVL_W), .RSSI_W(RSSI_W)) i_rx_immunity_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ofdm_trig_i(ofdm), .cck_trig_i(cck), .lower_req_i(lower),
        .reset_req_i(rreq), .restore_i(restore),
        .set_req_i(setr), .set_sel_i(sel), .set_val_i(val),
        .rssi_i(rssi), .rssi_lo_i(thr_lo), .rssi_hi_i(thr_hi),
        .rssi_en_i(rssi_en), .cck_chan_i(cck_chan),
        .max_ni_i(max_ni), .max_si_i(max_si), .max_fs_i(max_fs),
        .ni_lvl_o(ni), .si_lvl_o(si), .fs_lvl_o(fs),
        .wsd_on_o(wsd), .cck_thr_hi_o(cckhi),
        .ni_up_o(ni_up), .ni_dn_o(ni_dn), .si_up_o(si_up), .si_dn_o(si_dn),
        .fs_up_o(fs_up), .fs_dn_o(fs_dn), .done_o(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_st(input string tag, input int e_ni, input int e_si, input int e_fs,
                          input int e_wsd, input int e_cck);
        chk({tag, " ni"}, ni, e_ni);
        chk({tag, " si"}, si, e_si);
        chk({tag, " fs"}, fs, e_fs);
        chk({tag, " wsd"}, wsd, e_wsd);
        chk({tag, " cck"}, cckhi, e_cck);
    endtask

    // Drive one event for one cycle; return at the next falling edge
    task automatic ev(input logic o, input logic c, input logic l, input logic r,
                      input logic rs, input logic s, input logic [2:0] sl, input logic [LVL_W-1:0] v);
        @(negedge clk);
        ofdm = o; cck = c; lower = l; rreq = r; restore = rs; setr = s; sel = sl; val = v;
        @(negedge clk);
        ofdm = 0; cck = 0; lower = 0; rreq = 0; restore = 0; setr = 0; sel = '0; val = '0;
    endtask

    task automatic do_ofdm();  ev(1,0,0,0,0,0,3'd0,3'd0); endtask
    task automatic do_cck();   ev(0,1,0,0,0,0,3'd0,3'd0); endtask
    task automatic do_lower(); ev(0,0,1,0,0,0,3'd0,3'd0); endtask
    task automatic do_clear(); ev(0,0,0,1,0,0,3'd0,3'd0); endtask
    task automatic do_set(input logic [2:0] sl, input logic [LVL_W-1:0] v); ev(0,0,0,0,0,1,sl,v); endtask

    task automatic t_reset_state();
        chk_st("R2 power-on", 0, 0, 0, 1, 0);
        chk("R1 no done at reset", done, 0);
    endtask

    task automatic t_ofdm_ladder();
        do_clear();
        rssi = 8'sd50;
        do_ofdm(); chk_st("R3 ofdm1", 1, 0, 0, 1, 0);
        chk("R12 ni_up", ni_up, 1); chk("R1 done", done, 1);
        @(negedge clk); chk("R1 done one cycle", done, 0); chk("R12 ni_up one cycle", ni_up, 0);
        do_ofdm(); chk_st("R3 ofdm2", 2, 0, 0, 1, 0);
        do_ofdm(); chk_st("R3 ofdm3 spur", 2, 1, 0, 1, 0); chk("R12 si_up", si_up, 1);
        do_ofdm(); chk_st("R3 ofdm4 spur", 2, 2, 0, 1, 0);
        do_ofdm(); chk_st("R4 high wsd off", 2, 0, 0, 0, 0); chk("R12 si_dn", si_dn, 1);
        do_ofdm(); chk_st("R3 spur again", 2, 1, 0, 0, 0);
        do_ofdm(); chk_st("R3 spur max", 2, 2, 0, 0, 0);
        do_ofdm(); chk_st("R4 high fs up", 2, 2, 1, 0, 0); chk("R12 fs_up", fs_up, 1);
        do_ofdm(); chk_st("R4 high fs max", 2, 2, 2, 0, 0);
        do_ofdm(); chk_st("R4 all max", 2, 2, 2, 0, 0); chk("R1 done no-op", done, 1);
    endtask

    task automatic t_ofdm_mid();
        do_clear();
        do_set(3'd0, 3'd2); do_set(3'd1, 3'd2); do_set(3'd3, 3'd0);
        chk_st("R11 setup", 2, 2, 0, 0, 0);
        rssi = 8'sd20;
        do_ofdm(); chk_st("R5 mid wsd on and fs", 2, 2, 1, 1, 0);
        do_ofdm(); chk_st("R5 mid fs2", 2, 2, 2, 1, 0);
        do_ofdm(); chk_st("R5 mid max", 2, 2, 2, 1, 0);
    endtask

    task automatic t_ofdm_low();
        do_clear();
        do_set(3'd0, 3'd2); do_set(3'd1, 3'd2); do_set(3'd2, 3'd2);
        rssi = 8'sd5; cck_chan = 1'b0;
        do_ofdm(); chk_st("R6 low non-cck", 2, 2, 2, 1, 0);
        cck_chan = 1'b1;
        do_ofdm(); chk_st("R6 low cck", 2, 2, 0, 0, 0); chk("R12 fs_dn", fs_dn, 1);
        do_set(3'd2, 3'd1);
        rssi_en = 1'b0;
        do_ofdm(); chk_st("R6 rssi disabled", 2, 2, 1, 0, 0);
        rssi_en = 1'b1; cck_chan = 1'b0;
    endtask

    task automatic t_cck();
        do_clear();
        rssi = 8'sd50;
        do_cck(); chk_st("R7 cck ni1", 1, 0, 0, 1, 0);
        do_cck(); chk_st("R7 cck ni2", 2, 0, 0, 1, 0);
        do_cck(); chk_st("R7 cck high fs1", 2, 0, 1, 1, 0);
        rssi = 8'sd20;
        do_cck(); chk_st("R7 cck mid fs2", 2, 0, 2, 1, 0);
        do_cck(); chk_st("R7 cck at max", 2, 0, 2, 1, 0);
        rssi = 8'sd5;
        do_cck(); chk_st("R7 cck low non-cck", 2, 0, 2, 1, 0);
        cck_chan = 1'b1;
        do_cck(); chk_st("R7 cck low cck chan", 2, 0, 0, 1, 0);
        cck_chan = 1'b0;
    endtask

    task automatic t_lower();
        do_clear();
        do_set(3'd0, 3'd2); do_set(3'd1, 3'd1); do_set(3'd2, 3'd2); do_set(3'd3, 3'd0);
        rssi = 8'sd50;
        do_lower(); chk_st("R8 high spur down", 2, 0, 2, 0, 0);
        do_lower(); chk_st("R8 high noise down", 1, 0, 2, 0, 0); chk("R12 ni_dn", ni_dn, 1);
        rssi = 8'sd20;
        do_lower(); chk_st("R9 mid wsd on", 1, 0, 2, 1, 0);
        do_lower(); chk_st("R9 mid fs1", 1, 0, 1, 1, 0);
        do_lower(); chk_st("R9 mid fs0", 1, 0, 0, 1, 0);
        do_lower(); chk_st("R9 mid fall through", 0, 0, 0, 1, 0);
        do_lower(); chk_st("R9 floor", 0, 0, 0, 1, 0);
        rssi = 8'sd5;
        do_set(3'd2, 3'd1);
        do_lower(); chk_st("R10 low fs down", 0, 0, 0, 1, 0);
        do_set(3'd1, 3'd1);
        do_lower(); chk_st("R10 low fall through", 0, 0, 0, 1, 0);
    endtask

    task automatic t_set();
        do_clear();
        do_set(3'd0, 3'd3); chk_st("R11 reject ni", 0, 0, 0, 1, 0); chk("R11 done", done, 1);
        do_set(3'd1, 3'd2); chk_st("R11 si write", 0, 2, 0, 1, 0);
        do_set(3'd5, 3'd1); chk_st("R11 unused code", 0, 2, 0, 1, 0);
        do_set(3'd4, 3'd1); chk_st("R11 cck thr", 0, 2, 0, 1, 1);
        do_set(3'd2, 3'd3); chk_st("R11 reject fs", 0, 2, 0, 1, 1);
    endtask

    task automatic t_restore();
        ev(0,0,0,1,1,0,3'd0,3'd0); chk_st("R2 restore keeps", 0, 2, 0, 1, 1);
        ev(0,0,0,1,0,0,3'd0,3'd0); chk_st("R2 defaults", 0, 0, 0, 1, 0);
    endtask

    task automatic t_priority();
        do_clear();
        rssi = 8'sd20;
        ev(1,0,1,0,0,0,3'd0,3'd0); chk_st("R1 ofdm beats lower", 1, 0, 0, 1, 0);
        ev(1,0,0,0,0,1,3'd0,3'd0); chk_st("R1 set beats ofdm", 0, 0, 0, 1, 0);
        ev(1,0,0,1,0,1,3'd1,3'd2); chk_st("R1 reset beats set", 0, 0, 0, 1, 0);
        ev(0,1,1,0,0,0,3'd0,3'd0); chk_st("R1 cck beats lower", 1, 0, 0, 1, 0);
        @(negedge clk); chk("R1 idle no done", done, 0); chk_st("R1 idle hold", 1, 0, 0, 1, 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ofdm_ladder();
        t_ofdm_mid();
        t_ofdm_low();
        t_cck();
        t_lower();
        t_set();
        t_restore();
        t_priority();
        report();
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule